// File: doc/BRIEF.md
# PWM Output Event Action Logic

This block drives a single PWM output pin from the event pulses of a PWM timebase. The timebase reports six kinds of event. Two come from the counter itself: it reached zero, or it reached its load value. The other four come from two comparators, A and B, and each comparator reports separately whether the match happened while counting up or while counting down. A 12-bit action word gives each event a 2-bit action. The action can leave the output alone, invert it, force it low or force it high. The output is held in a flip-flop and changes on the clock edge at which an event carrying a non-zero action is presented.

Several events can arrive in the same cycle, and a fixed priority picks the one that acts. The counter events win over compare events, and zero wins over load. The tie between the two comparators depends on the `OUT_SEL` parameter. An instance built for output A (`OUT_SEL` = 0) favours comparator A. An instance built for output B (`OUT_SEL` = 1) favours comparator B. When the timebase runs in count-down mode, the block ignores the two up-count compare events. The counter, dead-band insertion and register access are outside this block.

Top module: `pwm_evt_action`

## Requirements
- R1: Under reset (rst_n low) and on the first cycle after it, pwm_out is 0.
- R2: Action code values: 0 leaves pwm_out unchanged, 1 inverts it, 2 drives it to 0, 3 drives it to 1; the new value appears after the rising clock edge at which the event is presented.
- R3: Action word fields: zero event uses act_word[1:0], load uses [3:2], compare A counting up uses [5:4], compare A counting down uses [7:6], compare B counting up uses [9:8], compare B counting down uses [11:10].
- R4: With updown_mode = 0 (count-down), ev_cmpa_up and ev_cmpb_up have no effect on pwm_out; with updown_mode = 1 they act through their fields.
- R5: When a zero or load event arrives in the same cycle as any compare event, only the zero or load action is applied.
- R6: When zero and load arrive together, only the zero action is applied.
- R7: With OUT_SEL = 0, a compare A event together with a compare B event (and no zero or load) applies only the compare A action.
- R8: With OUT_SEL = 1, a compare A event together with a compare B event (and no zero or load) applies only the compare B action.
- R9: pwm_out changes only at a clock edge where an accepted event with a non-zero action wins the priority; with no event, or a winning action of 0, it holds.
- R10: The action word is sampled at the event itself, so a change to act_word takes effect on the next event after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| updown_mode | input | 1 | 1 = timebase counts up/down, 0 = count-down only |
| ev_zero | input | 1 | Counter-equals-zero event pulse |
| ev_load | input | 1 | Counter-equals-load event pulse |
| ev_cmpa_up | input | 1 | Comparator A match while counting up |
| ev_cmpa_dn | input | 1 | Comparator A match while counting down |
| ev_cmpb_up | input | 1 | Comparator B match while counting up |
| ev_cmpb_dn | input | 1 | Comparator B match while counting down |
| act_word | input | 12 | Six 2-bit action fields, one per event |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The assertions assume that a comparator never reports an up-count match and a down-count match in the same cycle, because a real counter has only one direction at a time. One assertion states this assumption. The stimulus keeps to it: when the bench generates compare events at random, it picks a single direction per comparator each cycle. Every other combination of events is allowed, and the bench drives one output-A instance and one output-B instance from the same inputs so that each tie-break is seen under the same events.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;
   localparam int N_EVT = 6;
   localparam int ACT_W = 2;

   // event slot indices; slot i owns action bits [2i+1:2i]
   localparam int EVT_ZERO = 0;
   localparam int EVT_LOAD = 1;
   localparam int EVT_CAU  = 2;
   localparam int EVT_CAD  = 3;
   localparam int EVT_CBU  = 4;
   localparam int EVT_CBD  = 5;

   typedef enum logic [ACT_W-1:0] {
      ACT_HOLD   = 2'd0,
      ACT_TOGGLE = 2'd1,
      ACT_CLEAR  = 2'd2,
      ACT_SET    = 2'd3
   } act_e;
endpackage

// File: rtl/pwm_evt_gate.sv
module pwm_evt_gate
   import pwm_evt_pkg::*;
#(
   parameter int NE = N_EVT
)(
   input  logic          updown_mode,
   input  logic [NE-1:0] ev_raw,
   output logic [NE-1:0] ev_q
);
   genvar i;
   generate
      for (i = 0; i < NE; i++) begin : g_slot
         if (i == EVT_CAU || i == EVT_CBU) begin : g_up
            assign ev_q[i] = ev_raw[i] & updown_mode;
         end else begin : g_pass
            assign ev_q[i] = ev_raw[i];
         end
      end
   endgenerate
endmodule

// File: rtl/pwm_evt_prio.sv
module pwm_evt_prio
   import pwm_evt_pkg::*;
#(
   parameter int OUT_SEL = 0,
   parameter int NE      = N_EVT,
   parameter int AW      = ACT_W,
   localparam int WW     = NE * AW
)(
   input  logic [NE-1:0] ev,
   input  logic [WW-1:0] act_word,
   output logic          sel_hit,
   output act_e          sel_act
);
   logic [AW-1:0] fld [NE];
   genvar i;
   generate
      for (i = 0; i < NE; i++) begin : g_fld
         assign fld[i] = act_word[i*AW +: AW];
      end
   endgenerate

   logic          a_hit, b_hit, p_hit, s_hit;
   logic [AW-1:0] a_act, b_act, p_act, s_act;

   assign a_hit = ev[EVT_CAU] | ev[EVT_CAD];
   assign a_act = ev[EVT_CAU] ? fld[EVT_CAU] : fld[EVT_CAD];
   assign b_hit = ev[EVT_CBU] | ev[EVT_CBD];
   assign b_act = ev[EVT_CBU] ? fld[EVT_CBU] : fld[EVT_CBD];

   generate
      if (OUT_SEL == 0) begin : g_out_a
         assign p_hit = a_hit;  assign p_act = a_act;
         assign s_hit = b_hit;  assign s_act = b_act;
      end else begin : g_out_b
         assign p_hit = b_hit;  assign p_act = b_act;
         assign s_hit = a_hit;  assign s_act = a_act;
      end
   endgenerate

   always_comb begin
      sel_hit = 1'b1;
      if (ev[EVT_ZERO])      sel_act = act_e'(fld[EVT_ZERO]);
      else if (ev[EVT_LOAD]) sel_act = act_e'(fld[EVT_LOAD]);
      else if (p_hit)        sel_act = act_e'(p_act);
      else if (s_hit)        sel_act = act_e'(s_act);
      else begin
         sel_hit = 1'b0;
         sel_act = ACT_HOLD;
      end
   end
endmodule

// File: rtl/pwm_evt_outreg.sv
module pwm_evt_outreg
   import pwm_evt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sel_hit,
   input  act_e sel_act,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else if (sel_hit) begin
         case (sel_act)
            ACT_TOGGLE: q <= ~q;
            ACT_CLEAR:  q <= 1'b0;
            ACT_SET:    q <= 1'b1;
            default:    q <= q;
         endcase
      end
   end

   assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_hit && sel_act == ACT_CLEAR) |=> !q);
   assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_hit && sel_act == ACT_SET) |=> q);
   assert_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_hit && sel_act == ACT_TOGGLE) |=> (q != $past(q)));
   assert_rst_low_R1: assert property (@(posedge clk)
      !rst_n |=> !q);
endmodule

// File: rtl/pwm_evt_action.sv
module pwm_evt_action
   import pwm_evt_pkg::*;
#(
   parameter int OUT_SEL = 0,
   parameter int AW      = ACT_W,
   localparam int WW     = N_EVT * AW
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          updown_mode,
   input  logic          ev_zero,
   input  logic          ev_load,
   input  logic          ev_cmpa_up,
   input  logic          ev_cmpa_dn,
   input  logic          ev_cmpb_up,
   input  logic          ev_cmpb_dn,
   input  logic [WW-1:0] act_word,
   output logic          pwm_out
);
   generate
      if (OUT_SEL != 0 && OUT_SEL != 1) begin : g_bad_sel
         $error("pwm_evt_action: OUT_SEL must be 0 or 1");
      end
      if (AW != ACT_W) begin : g_bad_aw
         $error("pwm_evt_action: action field width must match act_e");
      end
   endgenerate

   logic [N_EVT-1:0] ev_raw, ev_q;
   logic             sel_hit;
   act_e             sel_act;

   assign ev_raw = {ev_cmpb_dn, ev_cmpb_up, ev_cmpa_dn, ev_cmpa_up, ev_load, ev_zero};

   pwm_evt_gate #(.NE(N_EVT)) u_gate (
      .updown_mode(updown_mode), .ev_raw(ev_raw), .ev_q(ev_q));

   pwm_evt_prio #(.OUT_SEL(OUT_SEL), .NE(N_EVT), .AW(AW)) u_prio (
      .ev(ev_q), .act_word(act_word), .sel_hit(sel_hit), .sel_act(sel_act));

   pwm_evt_outreg u_oreg (
      .clk(clk), .rst_n(rst_n), .sel_hit(sel_hit), .sel_act(sel_act), .q(pwm_out));

   // input assumption: a comparator reports one direction at a time (R4)
   assert_dir_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev_cmpa_up && ev_cmpa_dn) && !(ev_cmpb_up && ev_cmpb_dn));

   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_raw == '0) |=> $stable(pwm_out));

   assert_down_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!updown_mode && !ev_zero && !ev_load && !ev_cmpa_dn && !ev_cmpb_dn)
      |=> $stable(pwm_out));

   assert_zero_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_zero && act_word[1:0] == 2'd3) |=> pwm_out);

   assert_zero_over_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_zero && ev_load && act_word[1:0] == 2'd2) |=> !pwm_out);

   generate
      if (OUT_SEL == 0) begin : g_chk_a
         assert_tie_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!ev_zero && !ev_load && ev_cmpa_dn && ev_cmpb_dn && !ev_cmpa_up
             && act_word[7:6] == 2'd3) |=> pwm_out);
      end else begin : g_chk_b
         assert_tie_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!ev_zero && !ev_load && ev_cmpa_dn && ev_cmpb_dn && !ev_cmpb_up
             && act_word[11:10] == 2'd3) |=> pwm_out);
      end
   endgenerate
endmodule

// File: tb/pwm_evt_action_tb.sv
module pwm_evt_action_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        updown_mode = 1'b0;
   logic [5:0]  ev = '0;       // {cbd,cbu,cad,cau,load,zero}
   logic [11:0] act_word = '0;
   logic        out_a, out_b;

   always #5 clk = ~clk;

   pwm_evt_action #(.OUT_SEL(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .updown_mode(updown_mode),
      .ev_zero(ev[0]), .ev_load(ev[1]), .ev_cmpa_up(ev[2]), .ev_cmpa_dn(ev[3]),
      .ev_cmpb_up(ev[4]), .ev_cmpb_dn(ev[5]), .act_word(act_word), .pwm_out(out_a));

   pwm_evt_action #(.OUT_SEL(1)) u_dut_b (
      .clk(clk), .rst_n(rst_n), .updown_mode(updown_mode),
      .ev_zero(ev[0]), .ev_load(ev[1]), .ev_cmpa_up(ev[2]), .ev_cmpa_dn(ev[3]),
      .ev_cmpb_up(ev[4]), .ev_cmpb_dn(ev[5]), .act_word(act_word), .pwm_out(out_b));

   typedef struct { logic a; logic b; string tag; } exp_t;
   exp_t sb_q[$];
   int   n_chk = 0, n_fail = 0;
   logic mdl_a = 1'b0, mdl_b = 1'b0;

   function automatic logic nxt(logic cur, logic md, logic [5:0] e, logic [11:0] w, bit isb);
      logic [5:0] m;
      logic [1:0] act, fa, fb;
      logic       ha, hb;
      m = e;
      if (!md) begin m[2] = 1'b0; m[4] = 1'b0; end
      ha = m[2] | m[3];  fa = m[2] ? w[5:4] : w[7:6];
      hb = m[4] | m[5];  fb = m[4] ? w[9:8] : w[11:10];
      act = 2'd0;
      if (m[0])            act = w[1:0];
      else if (m[1])       act = w[3:2];
      else if (ha && hb)   act = isb ? fb : fa;
      else if (ha)         act = fa;
      else if (hb)         act = fb;
      case (act)
         2'd1: return ~cur;
         2'd2: return 1'b0;
         2'd3: return 1'b1;
         default: return cur;
      endcase
   endfunction

   task automatic step(logic md, logic [5:0] e, logic [11:0] w, string tag);
      exp_t x;
      @(negedge clk);
      updown_mode = md; ev = e; act_word = w;
      mdl_a = nxt(mdl_a, md, e, w, 1'b0);
      mdl_b = nxt(mdl_b, md, e, w, 1'b1);
      @(posedge clk);
      #1;
      x.a = mdl_a; x.b = mdl_b; x.tag = tag;
      sb_q.push_back(x);
   endtask

   // monitor: compares the registered outputs one half period after each edge
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t x;
         x = sb_q.pop_front();
         n_chk += 2;
         if (out_a !== x.a) begin
            n_fail++;
            $display("FAIL %s output A: actual %b expected %b", x.tag, out_a, x.a);
         end
         if (out_b !== x.b) begin
            n_fail++;
            $display("FAIL %s output B: actual %b expected %b", x.tag, out_b, x.b);
         end
      end
   end

   initial begin
      #2000000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      n_chk += 2;
      if (out_a !== 1'b0 || out_b !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 reset: actual %b%b expected 00", out_a, out_b);
      end
      @(negedge clk); rst_n = 1'b1;

      step(1'b1, 6'b000000, 12'hFFF, "R9 no event holds");
      step(1'b0, 6'b000001, 12'h003, "R2 R3 zero set");
      step(1'b0, 6'b000001, 12'h001, "R2 zero invert");
      step(1'b0, 6'b000010, 12'h00C, "R3 load set");
      step(1'b0, 6'b001000, 12'h080, "R3 cmpa down clear");
      step(1'b0, 6'b000100, 12'h030, "R4 down mode ignores cmpa up");
      step(1'b0, 6'b010000, 12'h300, "R4 down mode ignores cmpb up");
      step(1'b1, 6'b000100, 12'h030, "R3 R4 updown cmpa up set");
      step(1'b1, 6'b010000, 12'h200, "R3 cmpb up clear");
      step(1'b1, 6'b100000, 12'hC00, "R3 cmpb down set");
      step(1'b1, 6'b001001, 12'h0C2, "R5 zero beats cmpa");
      step(1'b1, 6'b100010, 12'h80C, "R5 load beats cmpb");
      step(1'b1, 6'b000011, 12'h00E, "R6 zero beats load");
      step(1'b1, 6'b101000, 12'h8C0, "R7 R8 compare tie set A clear B");
      step(1'b1, 6'b010100, 12'hC20, "R7 R8 compare tie up");
      step(1'b1, 6'b000001, 12'hFFC, "R9 zero action zero holds");
      step(1'b1, 6'b000000, 12'h001, "R10 word toggle no event");
      step(1'b1, 6'b000001, 12'h002, "R10 new word clear used");
      step(1'b1, 6'b000001, 12'h003, "R10 new word set used");

      for (int i = 0; i < 60; i++) begin
         logic [5:0] e;
         logic [31:0] r;
         r = $urandom;
         e = r[5:0];
         if (e[2] && e[3]) e[r[6] ? 2 : 3] = 1'b0;
         if (e[4] && e[5]) e[r[7] ? 4 : 5] = 1'b0;
         step(r[8], e, r[31:20], "R2 R5 R7 R8 mixed events");
      end

      @(negedge clk); ev = '0;
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule